// File: doc/BRIEF.md
# Ten-bit word serializer with wrap-around path

The block turns a pre-encoded parallel word into a serial bit stream on a bit clock that runs ten times as fast as the word rate. The bit clock is the block's only clock. A strobe that is high for one bit-clock cycle in every ten marks the word boundary. The word present at that edge is loaded, and its bits then leave one per cycle, lowest bit first. The next strobe follows straight after the last bit, so there is no gap between words.

A wrap-enable input sets the test mode. With wrap-enable low, the line output carries the stream and the receive-side selector passes the external serial input. With wrap-enable high, the line output is held at a fixed idle level of 0 and the selector passes the block's own stream instead. This tests the receive path without the medium. A dedicated wrap output always carries the stream in both modes.

Top module: `ser10_loop`

## Requirements
- R1: On a rising clock edge with `byte_stb_i` high, `word_i` is loaded, and its bit 0 appears on `ser_wrap_o` in the cycle that follows that edge.
- R2: One word takes exactly ten bit cycles, so words strobed every ten cycles leave back to back with no idle bit between them.
- R3: Bits leave least significant first: bit k of the loaded word is on `ser_wrap_o` k cycles after bit 0.
- R4: While `wrap_en_i` is high, `ser_line_o` is held at logic 0, whatever the data.
- R5: While `wrap_en_i` is high, `rx_bit_o` carries the internal stream (equal to `ser_wrap_o`) and ignores `ser_line_i`.
- R6: While `wrap_en_i` is low, `ser_line_o` carries the stream and `rx_bit_o` follows `ser_line_i`.
- R7: `ser_wrap_o` carries the serial stream in both modes.
- R8: After reset the shift register is all zeros and the serial outputs are 0 until the first load. In cycles without a strobe, zeros shift in, so the output returns to 0 once a word has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | 10 | Parallel word to send, bit 0 first |
| byte_stb_i | input | 1 | Word boundary strobe, one cycle in ten |
| wrap_en_i | input | 1 | 1 = internal wrap test mode |
| ser_line_i | input | 1 | External serial input toward the receiver |
| ser_line_o | output | 1 | External serial output, 0 in wrap mode |
| ser_wrap_o | output | 1 | Internal wrap stream |
| rx_bit_o | output | 1 | Serial bit selected for the receiver |

## Verification
The words with a single bit set at either end (bit 0 only, bit 9 only) show whether the bit order is reversed or the load slips by a cycle. The alternating words 0x155 and 0x2AA, all ones, and comma-like words sent back to back expose a stuck bit or an idle gap between words. The whole word set is sent once in each mode, with a pseudo-random external input, so the output hold and both selector paths are seen with the same stream. Quiet cycles after reset and after the final word check the zero fill.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

   parameter int unsigned SER_WORD_W = 10;

   typedef enum logic {
      PATH_LINE = 1'b0,
      PATH_WRAP = 1'b1
   } rx_path_e;

endpackage

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
   parameter int unsigned WORD_W    = ser10_pkg::SER_WORD_W,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              bit_o
);

   localparam int unsigned FIRST_IX = LSB_FIRST ? 0 : WORD_W - 1;
   localparam int unsigned NEXT_IX  = LSB_FIRST ? 1 : WORD_W - 2;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("ser10_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb sh_next = {1'b0, sh_q[WORD_W-1:1]};
      end else begin : g_msb
         always_comb sh_next = {sh_q[WORD_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (load_i)
         sh_q <= word_i;
      else
         sh_q <= sh_next;
   end

   assign bit_o = sh_q[FIRST_IX];

   // R1: the first bit of a strobed word appears in the next cycle
   a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> bit_o == $past(word_i[FIRST_IX]));

   // R3: without a strobe, the next bit in order follows
   a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> bit_o == $past(sh_q[NEXT_IX]));

endmodule

// File: rtl/ser10_txgate.sv
module ser10_txgate #(
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic wrap_en_i,
   input  logic bit_i,
   output logic line_o,
   output logic wrap_o
);

   assign line_o = wrap_en_i ? IDLE_LVL : bit_i;
   assign wrap_o = bit_i;

endmodule

// File: rtl/ser10_rxsel.sv
module ser10_rxsel (
   input  ser10_pkg::rx_path_e path_i,
   input  logic                line_i,
   input  logic                wrap_i,
   output logic                bit_o
);

   always_comb begin
      unique case (path_i)
         ser10_pkg::PATH_WRAP: bit_o = wrap_i;
         default:              bit_o = line_i;
      endcase
   end

endmodule

// File: rtl/ser10_loop.sv
module ser10_loop #(
   parameter int unsigned WORD_W    = ser10_pkg::SER_WORD_W,
   parameter bit          LSB_FIRST = 1'b1,
   parameter bit          IDLE_LVL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              byte_stb_i,
   input  logic              wrap_en_i,
   input  logic              ser_line_i,
   output logic              ser_line_o,
   output logic              ser_wrap_o,
   output logic              rx_bit_o
);

   logic                stream_bit;
   ser10_pkg::rx_path_e rx_path;

   assign rx_path = wrap_en_i ? ser10_pkg::PATH_WRAP : ser10_pkg::PATH_LINE;

   ser10_shifter #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (byte_stb_i),
      .word_i (word_i),
      .bit_o  (stream_bit)
   );

   ser10_txgate #(.IDLE_LVL(IDLE_LVL)) u_txgate (
      .wrap_en_i (wrap_en_i),
      .bit_i     (stream_bit),
      .line_o    (ser_line_o),
      .wrap_o    (ser_wrap_o)
   );

   ser10_rxsel u_rxsel (
      .path_i (rx_path),
      .line_i (ser_line_i),
      .wrap_i (ser_wrap_o),
      .bit_o  (rx_bit_o)
   );

   // R4: line output does not move while wrap mode persists
   a_r4_line_static: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_en_i && $past(wrap_en_i)) |-> $stable(ser_line_o));

   // R5: receiver sees the internal stream in wrap mode
   a_r5_rx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_en_i |-> rx_bit_o == ser_wrap_o);

   // R6: receiver sees the external input in normal mode
   a_r6_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_en_i |-> rx_bit_o == ser_line_i);

   // R6: line output mirrors the stream in normal mode
   a_r6_line_data: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_en_i |-> ser_line_o == ser_wrap_o);

endmodule

// File: tb/ser10_loop_tb.sv
module ser10_loop_tb;

   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] word_drv = '0;
   logic         stb_drv = 1'b0;
   logic         lb_mode = 1'b0;
   logic         line_drv = 1'b0;
   logic         ser_line_o, ser_wrap_o, rx_bit_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit exp_q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   ser10_loop u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (word_drv),
      .byte_stb_i (stb_drv),
      .wrap_en_i  (lb_mode),
      .ser_line_i (line_drv),
      .ser_line_o (ser_line_o),
      .ser_wrap_o (ser_wrap_o),
      .rx_bit_o   (rx_bit_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   // external input: pseudo-random, changed just after each rising edge
   always @(posedge clk) begin
      #2;
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      line_drv <= lfsr[0];
   end

   // monitor: one expected stream bit per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         bit b;
         b = exp_q.pop_front();
         check("R1/R2/R3/R7 stream", ser_wrap_o, b);
         if (lb_mode) begin
            check("R4 line held 0", ser_line_o, 1'b0);
            check("R5 rx from wrap", rx_bit_o, b);
         end else begin
            check("R6 line data", ser_line_o, b);
            check("R6 rx from line", rx_bit_o, line_drv);
         end
      end
   end

   // driver: strobe one word, then nine quiet cycles
   task automatic send_word(input logic [W-1:0] w, input logic lb);
      @(posedge clk);
      #2;
      word_drv = w;
      stb_drv  = 1'b1;
      lb_mode  = lb;
      @(posedge clk);
      for (int i = 0; i < W; i++) exp_q.push_back(w[i]);
      #2;
      stb_drv  = 1'b0;
      word_drv = ~w;
      repeat (8) @(posedge clk);
   endtask

   task automatic check_idle(input string req);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(req, ser_wrap_o, 1'b0);
         check(req, ser_line_o, 1'b0);
      end
   endtask

   logic [W-1:0] pats [6] = '{10'h001, 10'h200, 10'h155, 10'h2AA, 10'h3FF, 10'h0F8};

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #2 rst_n = 1'b1;
            // R8: zeros after reset, no load yet
            check_idle("R8 reset zero");
            // R6 exercised on a quiet line too
            @(negedge clk);
            check("R6 rx idle", rx_bit_o, line_drv);
            for (int p = 0; p < 6; p++) send_word(pats[p], 1'b0);
            for (int p = 0; p < 6; p++) send_word(pats[p], 1'b1);
            send_word(10'h3E0, 1'b0);
            send_word(10'h21C, 1'b1);
            send_word(10'h0E3, 1'b0);
            repeat (W + 2) @(posedge clk);
            // R8: drained word leaves zeros
            check_idle("R8 drain zero");
         end
         begin
            #(20 * 100000);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      if (exp_q.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 queue: actual %0d left expected 0", exp_q.size());
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule